// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block holds a small set of independent timer channels behind a word-addressed register port. Each channel counts ticks of a slow time base. The slow clock is modelled as a one-cycle enable on the fast clock. Each channel divides that base through a shared prescaler and compares its counter with a programmed value. A match sets a sticky flag. In periodic mode a match also restarts the count from zero, so the interval is the compare value plus one counted tick. In continuous mode the counter keeps running through the match and wraps at all ones. A wrap that is not a match sets an overflow flag.

One shared start register holds a run bit per channel. A level interrupt line per channel stays high while its match flag is set, provided it is enabled and routed to the interrupt request. Software clears a flag by writing zero to it and writing ones everywhere it wants to leave untouched. A write to a counter does not land at once: the slow domain absorbs it on the second slow tick after the write.

Top module: `cmatch_timer`

## Requirements
- R1: After reset every register reads zero and every interrupt line is low.
- R2: Register map, in word addresses:
  - Word 0 is the start register. Bit i runs channel i.
  - Channel i occupies words 4+4i to 6+4i: control at offset 0, counter at offset 1, compare value at offset 2.
  - Control bits: bit 15 is the match flag, bit 14 the overflow flag, bit 8 the mode (1 = periodic, clear on match), bit 7 the interrupt enable, bits 5:4 the request route, bits 2:0 the clock select.
  - Bits of the control register that are not listed read zero.
- R3: The clock select picks the counting rate:
  - Code 7 advances the counter on every slow tick.
  - Codes 4, 5 and 6 advance it once per 8, 32 and 128 slow ticks. The divided rates come from one shared prescaler, so any 8, 32 or 128 consecutive slow ticks give exactly one step.
  - Codes 0 to 3 never advance the counter.
- R4: In periodic mode, a counting step taken while the counter equals the compare value sets the match flag and returns the counter to zero. The period is therefore compare+1 steps.
- R5: In continuous mode, a step at the compare value sets the match flag and the counter still increments. A step from all ones to zero with no match sets the overflow flag. The overflow flag never sets in periodic mode.
- R6: While a channel's run bit is clear, its counter holds its value and its flags do not set.
- R7: A counter write takes effect on the second slow tick after the write. Until then the counter keeps its old value and reads it back, still counting.
- R8: In a control write, a 0 in a flag bit clears that flag and a 1 leaves it unchanged.
- R9: A channel's interrupt line equals match flag AND enable AND (route code == 2). Route codes 0, 1 and 3 keep the line low.
- R10: A counter value changes only in a cycle that follows a slow tick.
- R11: Channels are independent. Writes to, and running of, one channel leave another channel's counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slow_tick | input | 1 | One-cycle enable marking a slow time-base tick |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | NUM_CH | Level interrupt per channel |

## Verification
The tests run a channel with the following patterns:
- Periodic mode at full tick rate with a small compare value. This shows whether the restart comes on the match step and whether the interval is compare+1.
- Continuous mode started just below all ones. This separates a wrap, which gives overflow, from a pass through the compare value, which gives match with no clear.
- Each divided rate over a window of exactly one or two divider periods. The expected step count does not depend on the prescaler phase, so an error in the divider shows up as a wrong count.
- A counter write interleaved with running ticks. This shows that the old value keeps counting until the second tick.
- Flag writes with mixed ones and zeros, and each route code. These separate write-zero-to-clear from plain overwrite, and show that only route 2 raises the line.

// File: rtl/cmatch_pkg.sv
// Package: shared field positions, code values and the channel
// configuration type of the compare-match timer.
package cmatch_pkg;
    localparam int DATA_W  = 32;
    localparam int BIT_MF  = 15;
    localparam int BIT_OVF = 14;
    localparam int BIT_PER = 8;
    localparam int BIT_IE  = 7;
    localparam int REQ_LO  = 4;
    localparam int NUM_DIV = 4;   // rates: /1, /8, /32, /128

    localparam logic [1:0] ROUTE_IRQ = 2'd2;

    typedef enum logic [2:0] {
        SEL_D8   = 3'd4,
        SEL_D32  = 3'd5,
        SEL_D128 = 3'd6,
        SEL_D1   = 3'd7
    } rate_sel_e;

    typedef struct packed {
        logic       periodic;
        logic       int_en;
        logic [1:0] route;
        logic [2:0] sel;
    } chan_cfg_t;
endpackage

// File: rtl/cmatch_prescale.sv
// Module: cmatch_prescale
// Shared divider of the slow tick. Emits one-cycle enables at rates
// /1, /8, /32 and /128. Assumes slow_tick is a single-cycle pulse.
// The phase is fixed by reset: enable k of rate N fires on slow tick
// numbers that are multiples of N.
module cmatch_prescale
    import cmatch_pkg::*;
#(
    parameter int PRE_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slow_tick,
    output logic [NUM_DIV-1:0] rate_en
);
    logic [PRE_W-1:0] pre_q;

    // advance the shared divider once per slow tick
    always_ff @(posedge clk) begin
        if (!rst_n)         pre_q <= '0;
        else if (slow_tick) pre_q <= pre_q + 1'b1;
    end

    // one enable per rate: /1 plus /2^(2k+1) for k = 1..3
    for (genvar k = 0; k < NUM_DIV; k++) begin : g_rate
        localparam int LOWB = (k == 0) ? 0 : 2 * k + 1;
        if (LOWB == 0) begin : g_full
            assign rate_en[k] = slow_tick;
        end else begin : g_div
            assign rate_en[k] = slow_tick & (&pre_q[LOWB-1:0]);
        end
    end
endmodule

// File: rtl/cmatch_channel.sv
// Module: cmatch_channel
// One timer channel: configuration, sticky match and overflow flags,
// up-counter with delayed software load, compare value, interrupt.
// Assumes the write strobes are mutually exclusive and one cycle long.
module cmatch_channel
    import cmatch_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slow_tick,
    input  logic               run,
    input  logic [NUM_DIV-1:0] rate_en,
    input  logic               ctl_we,
    input  logic               cnt_we,
    input  logic               cmp_we,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  ctl_rd,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [CNT_W-1:0]   cmp_o,
    output logic               mflag_o,
    output logic               oflag_o,
    output logic               periodic_o,
    output logic               irq_o
);
    chan_cfg_t        cfg_q;
    logic             mflag_q, oflag_q;
    logic [CNT_W-1:0] cnt_q, cmp_q, load_val_q;
    logic             load_pend_q, load_half_q;
    logic             step, adv, apply, hit, at_top;
    logic             set_m, set_o;
    logic             unused_wbits;

    assign unused_wbits = ^{wdata[DATA_W-1:BIT_MF+1], wdata[BIT_OVF-1:BIT_PER+1],
                            wdata[BIT_IE-1:REQ_LO+2], wdata[REQ_LO-1:3]};

    // pick the counting enable from the clock select code
    always_comb begin
        case (cfg_q.sel)
            SEL_D1:   step = rate_en[0];
            SEL_D8:   step = rate_en[1];
            SEL_D32:  step = rate_en[2];
            SEL_D128: step = rate_en[3];
            default:  step = 1'b0;
        endcase
    end

    assign adv    = run & step;
    assign apply  = load_pend_q & load_half_q & slow_tick;
    assign hit    = (cnt_q == cmp_q);
    assign at_top = &cnt_q;
    assign set_m  = adv & ~apply & hit;
    assign set_o  = adv & ~apply & ~cfg_q.periodic & at_top & ~hit;

    // configuration and compare registers, loaded directly from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            cmp_q <= '0;
        end else begin
            if (ctl_we) cfg_q <= '{periodic: wdata[BIT_PER], int_en: wdata[BIT_IE],
                                   route: wdata[REQ_LO+1:REQ_LO], sel: wdata[2:0]};
            if (cmp_we) cmp_q <= wdata[CNT_W-1:0];
        end
    end

    // sticky flags: hardware set wins, a written 0 clears, a written 1 keeps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mflag_q <= 1'b0;
            oflag_q <= 1'b0;
        end else begin
            if (set_m)       mflag_q <= 1'b1;
            else if (ctl_we) mflag_q <= mflag_q & wdata[BIT_MF];
            if (set_o)       oflag_q <= 1'b1;
            else if (ctl_we) oflag_q <= oflag_q & wdata[BIT_OVF];
        end
    end

    // pending software load: lands on the second slow tick after the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_pend_q <= 1'b0;
            load_half_q <= 1'b0;
            load_val_q  <= '0;
        end else if (cnt_we) begin
            load_pend_q <= 1'b1;
            load_half_q <= 1'b0;
            load_val_q  <= wdata[CNT_W-1:0];
        end else if (apply) begin
            load_pend_q <= 1'b0;
            load_half_q <= 1'b0;
        end else if (load_pend_q && slow_tick) begin
            load_half_q <= 1'b1;
        end
    end

    // counter: load, restart on periodic match, or increment
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (apply)                 cnt_q <= load_val_q;
        else if (adv && hit && cfg_q.periodic) cnt_q <= '0;
        else if (adv)                   cnt_q <= cnt_q + 1'b1;
    end

    // read-back and outputs
    always_comb begin
        ctl_rd                       = '0;
        ctl_rd[BIT_MF]               = mflag_q;
        ctl_rd[BIT_OVF]              = oflag_q;
        ctl_rd[BIT_PER]              = cfg_q.periodic;
        ctl_rd[BIT_IE]               = cfg_q.int_en;
        ctl_rd[REQ_LO+1:REQ_LO]      = cfg_q.route;
        ctl_rd[2:0]                  = cfg_q.sel;
    end

    assign cnt_o      = cnt_q;
    assign cmp_o      = cmp_q;
    assign mflag_o    = mflag_q;
    assign oflag_o    = oflag_q;
    assign periodic_o = cfg_q.periodic;
    assign irq_o      = mflag_q & cfg_q.int_en & (cfg_q.route == ROUTE_IRQ);
endmodule

// File: rtl/cmatch_timer.sv
// Module: cmatch_timer (top)
// Multi-channel compare-match timer with a word-addressed register
// port, a shared start register and a shared prescaler.
// Assumes NUM_CH+1 channel blocks fit in the address space and
// CNT_W <= 32. Reads are combinational and free of side effects.
module cmatch_timer
    import cmatch_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int BLK_W = ADDR_W - 2;

    logic [BLK_W-1:0]              blk;
    logic [1:0]                    idx;
    logic [NUM_CH-1:0]             run_q;
    logic [NUM_DIV-1:0]            rate_en;
    logic [DATA_W-1:0]             ctl_rd [NUM_CH];
    logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt;
    logic [NUM_CH-1:0][CNT_W-1:0]  ch_cmp;
    logic [NUM_CH-1:0]             ch_mf, ch_of, ch_per;

    assign blk = bus_addr[ADDR_W-1:2];
    assign idx = bus_addr[1:0];

    // shared start register: one run bit per channel
    always_ff @(posedge clk) begin
        if (!rst_n)                                 run_q <= '0;
        else if (bus_wr && blk == '0 && idx == 2'd0) run_q <= bus_wdata[NUM_CH-1:0];
    end

    cmatch_prescale #(.PRE_W(7)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .rate_en   (rate_en)
    );

    // one channel per block; block i+1 holds channel i
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel_blk;
        assign sel_blk = bus_wr && (blk == BLK_W'(i + 1));
        cmatch_channel #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .slow_tick  (slow_tick),
            .run        (run_q[i]),
            .rate_en    (rate_en),
            .ctl_we     (sel_blk && idx == 2'd0),
            .cnt_we     (sel_blk && idx == 2'd1),
            .cmp_we     (sel_blk && idx == 2'd2),
            .wdata      (bus_wdata),
            .ctl_rd     (ctl_rd[i]),
            .cnt_o      (ch_cnt[i]),
            .cmp_o      (ch_cmp[i]),
            .mflag_o    (ch_mf[i]),
            .oflag_o    (ch_of[i]),
            .periodic_o (ch_per[i]),
            .irq_o      (irq[i])
        );
    end

    // read multiplexer over the start register and channel blocks
    always_comb begin
        bus_rdata = '0;
        if (blk == '0 && idx == 2'd0) bus_rdata = DATA_W'(run_q);
        for (int i = 0; i < NUM_CH; i++) begin
            if (blk == BLK_W'(i + 1)) begin
                case (idx)
                    2'd0:    bus_rdata = ctl_rd[i];
                    2'd1:    bus_rdata = DATA_W'(ch_cnt[i]);
                    2'd2:    bus_rdata = DATA_W'(ch_cmp[i]);
                    default: bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/cmatch_timer_chk.sv
// Module: cmatch_timer_chk
// Property checker bound to cmatch_timer; observes channel state only.
module cmatch_timer_chk #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     slow_tick,
    input logic [NUM_CH-1:0]        irq,
    input logic [NUM_CH-1:0]        run_q,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
    input logic [NUM_CH-1:0]        ch_mf,
    input logic [NUM_CH-1:0]        ch_of,
    input logic [NUM_CH-1:0]        ch_per
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_prop
        // R9: a raised line needs a set match flag
        assert_irq_has_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> ch_mf[i]);
        // R10: the counter only moves after a slow tick
        assert_cnt_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !slow_tick |=> $stable(ch_cnt[i]));
        // R4: a match flag only rises from a slow tick
        assert_match_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_mf[i]) |-> $past(slow_tick));
        // R5: no overflow in periodic mode
        assert_no_ovf_periodic_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_of[i]) |-> !$past(ch_per[i]));
        // R6: a stopped channel raises no flag
        assert_stopped_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(ch_mf[i]) || $rose(ch_of[i])) |-> $past(run_q[i]));
    end
endmodule

bind cmatch_timer cmatch_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .irq       (irq),
    .run_q     (run_q),
    .ch_cnt    (ch_cnt),
    .ch_mf     (ch_mf),
    .ch_of     (ch_of),
    .ch_per    (ch_per)
);

// File: tb/cmatch_timer_bench.sv
// Directed bench for cmatch_timer: one task per scenario.
module cmatch_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int AW  = 6;
    localparam logic [31:0] MF = 32'h8000, OVF = 32'h4000, PER = 32'h100,
                            IE = 32'h80, RT_IRQ = 32'h20, RT_DMA = 32'h10;

    logic          clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0, bus_rdata;
    logic [NCH-1:0] irq;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    cmatch_timer #(.NUM_CH(NCH), .CNT_W(32), .ADDR_W(AW)) u_cmatch_timer (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [AW-1:0] ra(input int ch, input int off);
        return AW'(4 + 4 * ch + off);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(0, d);         chk("R1 start reg", d, 0);
        rd(ra(0, 0), d);  chk("R1 ctl0", d, 0);
        rd(ra(0, 1), d);  chk("R1 cnt0", d, 0);
        rd(ra(3, 2), d);  chk("R1 cmp3", d, 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_periodic;
        logic [31:0] d;
        wr(ra(0, 2), 3);
        wr(ra(0, 0), PER | IE | RT_IRQ | 7 | 32'h0000_3E48);
        rd(ra(0, 0), d); chk("R2 unused ctl bits read 0", d, PER | IE | RT_IRQ | 7);
        wr(0, 1);
        tick(3);
        rd(ra(0, 1), d); chk("R4 count to compare", d, 3);
        chk("R4 no flag before match step", 32'(irq[0]), 0);
        tick(1);
        rd(ra(0, 1), d); chk("R4 restart on match", d, 0);
        rd(ra(0, 0), d); chk("R4 flag set", d, MF | PER | IE | RT_IRQ | 7);
        chk("R9 irq raised", 32'(irq[0]), 1);
        tick(4);
        rd(ra(0, 1), d); chk("R4 period compare+1", d, 0);
    endtask

    task automatic t_flag_write;
        logic [31:0] d;
        wr(ra(0, 0), MF | OVF | PER | IE | RT_IRQ | 7);
        rd(ra(0, 0), d); chk("R8 writing 1 keeps flag", d & MF, MF);
        wr(ra(0, 0), PER | IE | RT_IRQ | 7);
        rd(ra(0, 0), d); chk("R8 writing 0 clears flag", d & MF, 0);
        chk("R9 irq drops with flag", 32'(irq[0]), 0);
        wr(ra(0, 0), MF | PER | IE | RT_IRQ | 7);
        rd(ra(0, 0), d); chk("R8 writing 1 sets nothing", d & MF, 0);
    endtask

    task automatic t_stop;
        logic [31:0] d;
        tick(2);
        wr(0, 0);
        tick(5);
        rd(ra(0, 1), d); chk("R6 stopped counter holds", d, 2);
    endtask

    task automatic t_load;
        logic [31:0] d;
        wr(ra(1, 2), 1000);
        wr(ra(1, 0), 7);
        wr(0, 2);
        wr(ra(1, 1), 500);
        rd(ra(1, 1), d); chk("R7 old value before ticks", d, 0);
        tick(1);
        rd(ra(1, 1), d); chk("R7 old value counts on first tick", d, 1);
        tick(1);
        rd(ra(1, 1), d); chk("R7 loaded on second tick", d, 500);
        tick(1);
        rd(ra(1, 1), d); chk("R7 counts from loaded value", d, 501);
        rd(ra(0, 1), d); chk("R11 other channel untouched", d, 2);
    endtask

    task automatic t_wrap;
        logic [31:0] d;
        wr(ra(1, 1), 32'hFFFF_FFFE);
        tick(2);
        rd(ra(1, 1), d); chk("R7 near-top load", d, 32'hFFFF_FFFE);
        tick(1);
        rd(ra(1, 0), d); chk("R5 no flag at top", d & (MF | OVF), 0);
        tick(1);
        rd(ra(1, 1), d); chk("R5 wrap to zero", d, 0);
        rd(ra(1, 0), d); chk("R5 overflow only", d & (MF | OVF), OVF);
        wr(ra(1, 2), 3);
        tick(4);
        rd(ra(1, 1), d); chk("R5 continuous passes compare", d, 4);
        rd(ra(1, 0), d); chk("R5 match in continuous", d & MF, MF);
    endtask

    task automatic t_route;
        logic [31:0] d;
        wr(ra(1, 0), MF | OVF | IE | RT_DMA | 7);
        chk("R9 route 1 keeps line low", 32'(irq[1]), 0);
        rd(ra(1, 0), d); chk("R8 flags kept by ones", d & (MF | OVF), MF | OVF);
        wr(ra(1, 0), MF | OVF | IE | 32'h30 | 7);
        chk("R9 route 3 keeps line low", 32'(irq[1]), 0);
        wr(ra(1, 0), MF | OVF | IE | RT_IRQ | 7);
        chk("R9 route 2 raises line", 32'(irq[1]), 1);
        wr(ra(1, 0), 0);
        chk("R9 zero write drops line", 32'(irq[1]), 0);
        rd(ra(1, 0), d); chk("R8 zero write clears both", d, 0);
    endtask

    task automatic t_rates;
        logic [31:0] d;
        wr(ra(2, 2), 32'hFFFF_FFFF);
        wr(ra(2, 0), 4);
        wr(0, 4);
        tick(16);
        rd(ra(2, 1), d); chk("R3 divide by 8", d, 2);
        wr(ra(2, 0), 2);
        tick(10);
        rd(ra(2, 1), d); chk("R3 code 2 does not count", d, 2);
        wr(ra(2, 0), 5);
        tick(64);
        rd(ra(2, 1), d); chk("R3 divide by 32", d, 4);
        wr(ra(2, 0), 6);
        tick(128);
        rd(ra(2, 1), d); chk("R3 divide by 128", d, 5);
        rd(ra(1, 1), d); chk("R11 stopped channel holds", d, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_periodic();
        t_flag_write();
        t_stop();
        t_load();
        t_wrap();
        t_route();
        t_rates();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule